// File: doc/BRIEF.md
# Word-to-Packet Write Framer

This block turns a run of 32-bit words into write packets for a byte-wide control channel. A start pulse carries a word count. The block then reads the words one at a time from a small source memory, by index, and emits one or more packets over a valid/ready byte stream. Every packet opens with a write opcode byte. After the opcode come up to eight fixed-size slots, one per word. Each slot holds the word's four bytes, least significant first, then two zero pad bytes, then an address tag byte. The tag is a base value plus the word's position in the whole transfer, so it keeps counting from one packet to the next.

The final byte of each packet is marked. The block then stops and waits for a one-cycle response from the channel below. An accept response moves the block on to the next packet, or ends the transfer if no words remain. An error response ends the transfer at once. In both cases a one-cycle done pulse reports the outcome, with an error flag.

Top module: `pkt_write_framer`

## Requirements
- R1: After reset, `out_valid`, `done` and `busy` are low.
- R2: The first byte of every packet is the opcode `OPCODE` (0x01 by default).
- R3: A packet holds `WORDS_PER_PKT` words (8), except the last one, which holds whatever remains. A packet of n words is 1+7n bytes long. `out_last` is high only on its final byte.
- R4: Word i of a packet occupies packet bytes 1+7i to 7+7i. Slot bytes 0 to 3 are the word, least significant byte first. Slot bytes 4 and 5 are zero. Slot byte 6 is the tag.
- R5: The tag equals `TAG_BASE` plus the word's absolute index within the transfer, modulo 256.
- R6: Once the last byte of a packet is accepted, no byte is offered until `rsp_valid` arrives. An accept response (`rsp_err`=0) on the final packet produces one `done` pulse with `done_err`=0 in the cycle after the response.
- R7: An error response (`rsp_err`=1) to any packet ends the transfer. `done` pulses with `done_err`=1 and no further packet is sent.
- R8: A start with count 0 gives a `done` pulse with `done_err`=0 in the next cycle and sends no packet. A start with a count above `MAX_WORDS` gives a `done` pulse with `done_err`=1 and sends no packet.
- R9: A start pulse while `busy` is high is ignored. A change of `word_count` after the accepted start has no effect.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer; sampled while idle |
| word_count | input | $clog2(MAX_WORDS+1) | Number of words to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_err | output | 1 | Error flag, valid with done |
| rd_idx | output | $clog2(MAX_WORDS) | Source memory word index |
| rd_data | input | 32 | Word at rd_idx, same cycle |
| out_data | output | 8 | Packet byte |
| out_valid | output | 1 | Byte valid |
| out_ready | input | 1 | Byte accepted when high with out_valid |
| out_last | output | 1 | Final byte of a packet |
| rsp_valid | input | 1 | Packet response strobe |
| rsp_err | input | 1 | Packet rejected, valid with rsp_valid |

## Verification
The bench builds the block with `MAX_WORDS`=16 and `WORDS_PER_PKT`=8, so both one-packet and two-packet transfers occur, including a last packet that carries only the remainder. `TAG_BASE` is set to 0xFA rather than the default. With that base the tag passes 0xFF at the seventh word, so the modulo-256 wrap is exercised inside ordinary transfers. Back-pressure on `out_ready` is random. The bench also injects error responses on the first and on later packets, and sends start pulses while a transfer is in progress.

// File: rtl/pkt_write_framer.sv
module pkt_write_framer #(
  parameter int MAX_WORDS = 16,
  parameter int WORDS_PER_PKT = 8,
  parameter logic [7:0] OPCODE = 8'h01,
  parameter logic [7:0] TAG_BASE = 8'h44,
  localparam int CNT_W = $clog2(MAX_WORDS + 1),
  localparam int IDX_W = $clog2(MAX_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] word_count,
  output logic             busy,
  output logic             done,
  output logic             done_err,
  output logic [IDX_W-1:0] rd_idx,
  input  logic [31:0]      rd_data,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_last,
  input  logic             rsp_valid,
  input  logic             rsp_err
);
  localparam int SI_W = $clog2(WORDS_PER_PKT + 1);

  typedef enum logic [1:0] {S_IDLE, S_HDR, S_SLOT, S_WAIT} state_t;

  state_t           state;
  logic [CNT_W-1:0] total, widx;
  logic [SI_W-1:0]  si;
  logic [2:0]       sb;
  logic [7:0]       slot_byte, tag;
  logic             last_word, pkt_full, fire;

  assign tag       = TAG_BASE + 8'(widx);
  assign last_word = widx == total - CNT_W'(1);
  assign pkt_full  = si == SI_W'(WORDS_PER_PKT - 1);
  assign out_valid = state == S_HDR || state == S_SLOT;
  assign fire      = out_valid && out_ready;
  assign out_last  = state == S_SLOT && sb == 3'd6 && (last_word || pkt_full);
  assign rd_idx    = widx[IDX_W-1:0];
  assign busy      = state != S_IDLE;

  always_comb begin
    case (sb)
      3'd0, 3'd1, 3'd2, 3'd3: slot_byte = rd_data[8*sb +: 8];
      3'd6:                   slot_byte = tag;
      default:                slot_byte = 8'h00;
    endcase
  end

  assign out_data = (state == S_HDR) ? OPCODE : slot_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      total    <= '0;
      widx     <= '0;
      si       <= '0;
      sb       <= '0;
      done     <= 1'b0;
      done_err <= 1'b0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (word_count == '0) begin
            done <= 1'b1;
          end else if (word_count > CNT_W'(MAX_WORDS)) begin
            done     <= 1'b1;
            done_err <= 1'b1;
          end else begin
            total <= word_count;
            widx  <= '0;
            state <= S_HDR;
          end
        end
        S_HDR: if (fire) begin
          si    <= '0;
          sb    <= '0;
          state <= S_SLOT;
        end
        S_SLOT: if (fire) begin
          if (sb == 3'd6) begin
            sb   <= '0;
            widx <= widx + CNT_W'(1);
            si   <= si + SI_W'(1);
            if (out_last) state <= S_WAIT;
          end else begin
            sb <= sb + 3'd1;
          end
        end
        S_WAIT: if (rsp_valid) begin
          if (rsp_err) begin
            done     <= 1'b1;
            done_err <= 1'b1;
            state    <= S_IDLE;
          end else if (widx == total) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_HDR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_write_framer_chk.sv
module pkt_write_framer_chk #(
  parameter int MAX_WORDS = 16,
  parameter logic [7:0] OPCODE = 8'h01,
  localparam int CNT_W = $clog2(MAX_WORDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [CNT_W-1:0] word_count,
  input logic             busy,
  input logic             done,
  input logic             done_err,
  input logic [7:0]       out_data,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last
);
  p_opcode_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_data == OPCODE);

  p_last_with_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_wait_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> done);

  p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && word_count == '0 |=> done && !done_err && !busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

bind pkt_write_framer pkt_write_framer_chk #(.MAX_WORDS(MAX_WORDS), .OPCODE(OPCODE)) u_chk (.*);

// File: tb/tb_pkt_write_framer.sv
module tb_pkt_write_framer;
  localparam int MAXW = 16;
  localparam int WPP = 8;
  localparam logic [7:0] TBASE = 8'hFA;
  localparam int CW = $clog2(MAXW + 1);
  localparam int IW = $clog2(MAXW);

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, out_ready = 1'b0, rsp_valid = 1'b0, rsp_err = 1'b0;
  logic [CW-1:0] word_count = '0;
  logic busy, done, done_err, out_valid, out_last;
  logic [IW-1:0] rd_idx;
  logic [7:0] out_data;
  logic [31:0] mem [MAXW];
  logic [31:0] rd_data;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #5 clk = ~clk;
  assign rd_data = mem[rd_idx];

  pkt_write_framer #(.MAX_WORDS(MAXW), .WORDS_PER_PKT(WPP), .TAG_BASE(TBASE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .word_count(word_count), .busy(busy),
    .done(done), .done_err(done_err), .rd_idx(rd_idx), .rd_data(rd_data),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int p, input int pos);
    int s, b, w;
    if (pos == 0) return 8'h01;
    s = (pos - 1) / 7; b = (pos - 1) % 7; w = p * WPP + s;
    if (b < 4) return mem[w][8*b +: 8];
    if (b == 6) return TBASE + 8'(w);
    return 8'h00;
  endfunction

  function automatic int pkt_len(input int p, input int cnt);
    int n = cnt - p * WPP;
    if (n > WPP) n = WPP;
    return 1 + 7 * n;
  endfunction

  task automatic run(input int cnt, input int err_pkt, input int gap, input bit inject);
    int pkt = 0, pos = 0, it = 0, exp_pkts;
    bit got = 0, gerr = 0, exp_err;
    for (int i = 0; i < MAXW; i++) mem[i] = $urandom;
    if (cnt == 0 || cnt > MAXW) exp_pkts = 0;
    else if (err_pkt >= 0) exp_pkts = err_pkt + 1;
    else exp_pkts = (cnt + WPP - 1) / WPP;
    exp_err = (cnt > MAXW) || (cnt > 0 && err_pkt >= 0);
    @(negedge clk); start = 1'b1; word_count = CW'(cnt);
    @(negedge clk); start = 1'b0; word_count = CW'($urandom);
    #1;
    if (done) begin got = 1; gerr = done_err; end
    while (!got && it < 4000) begin
      @(negedge clk); it++;
      out_ready = ($urandom % 4) != 0;
      start = inject && it == 3;
      word_count = inject && it == 3 ? '0 : word_count;
      #1;
      if (done) begin got = 1; gerr = done_err; break; end
      if (out_valid && out_ready) begin
        chk(out_data == exp_byte(pkt, pos), pos == 0 ? "R2" : (((pos-1)%7 == 6) ? "R5" : "R4"),
            out_data, exp_byte(pkt, pos));
        chk(out_last == (pos == pkt_len(pkt, cnt) - 1), "R3", out_last, pos == pkt_len(pkt, cnt) - 1);
        if (out_last) begin
          for (int g = 0; g < gap; g++) begin
            @(negedge clk); out_ready = 1'b1; start = 1'b0; #1;
            chk(!out_valid, "R6 idle until response", out_valid, 0);
          end
          @(negedge clk); out_ready = 1'b0; start = 1'b0;
          rsp_valid = 1'b1; rsp_err = (pkt == err_pkt);
          @(negedge clk); rsp_valid = 1'b0; rsp_err = 1'b0;
          pkt++; pos = 0;
          #1;
          if (done) begin got = 1; gerr = done_err; end
        end else pos++;
      end
    end
    start = 1'b0; out_ready = 1'b0;
    chk(got, "R6 done seen", got, 1);
    chk(gerr == exp_err, exp_err ? "R7 error flag" : "R6 error flag", gerr, exp_err);
    chk(pkt == exp_pkts, cnt == 0 || cnt > MAXW ? "R8 packets" : (inject ? "R9 packets" : "R7 packets"), pkt, exp_pkts);
    @(negedge clk); #1;
    chk(!done && !busy, "R6 idle after done", {busy, done}, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !done && !busy, "R1 reset state", {out_valid, done, busy}, 0);
    rst_n = 1'b1;
    run(0, -1, 0, 0);
    run(17, -1, 0, 0);
    run(31, -1, 0, 0);
    run(1, -1, 2, 0);
    run(8, -1, 0, 0);
    run(9, -1, 3, 0);
    run(16, -1, 1, 1);
    run(16, 0, 1, 0);
    run(16, 1, 0, 0);
    run(1, 0, 0, 0);
    for (int k = 0; k < 40; k++) begin
      int c = 1 + $urandom % MAXW;
      int np = (c + WPP - 1) / WPP;
      int e = ($urandom % 4 == 0) ? int'($urandom % np) : -1;
      run(c, e, $urandom % 4, $urandom % 3 == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule